// File: doc/BRIEF.md
# Tapped Binary Divider Chain

The block divides an incoming oscillator clock through a chain of fourteen divide-by-two stages and brings out a selected set of stage outputs as divided clocks. Stage n toggles at the input rate divided by 2^n. The chain is held in one count register that moves on the falling clock edge, so every tap changes in the same instant and the taps never show the ripple skew of a chain of cascaded flip-flops.

An active-high asynchronous clear empties the chain at once and drops an oscillator-enable output, so that an oscillator model outside the block can stop while the block stands by. The clear is released in step with the clock: the first falling edge after release only arms the chain, and the count moves from the second one on. To let downstream logic decode the count safely, the block compares the full count against a compare word. It registers the result on the rising edge, half a period after the count settles, and gives it out as a one-cycle strobe. A terminal flag marks the cycle in which every stage is high.

Top module: `divchain_top`

## Requirements
- R1: The count is 14 bits wide, rises by one per advance, and wraps from all ones (16383) to zero with no carry output.
- R2: The count changes only on a falling edge of `clk`. A rising edge leaves the taps unchanged.
- R3: `taps[6:0]` carry stages 4 to 10 (count bits 3 to 9, with `taps[0]` = stage 4). `taps[9:7]` carry stages 12 to 14 (count bits 11 to 13). Stages 1 to 3 and stage 11 never reach a port.
- R4: While `clr` is high, the count and every tap are zero. This takes effect at once, without waiting for a clock edge.
- R5: `osc_en` is low while `clr` is high and high while it is low.
- R6: After `clr` falls, the first falling edge leaves the count at zero. The count first becomes 1 on the second falling edge.
- R7: `strobe` is set on the rising edge that follows a count equal to `cmp` and lasts one clock cycle.
- R8: `tc` is high exactly while the count is all ones. The next advance after it brings the count, and every tap, to zero.
- R9: `strobe` and `tc` are low while `clr` is high, whatever `cmp` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the count moves on its falling edge |
| clr | input | 1 | Asynchronous clear, active high; also stops the oscillator |
| cmp | input | 14 | Compare word for the decode strobe |
| taps | output | 10 | Divided clocks: stages 4 to 10, then 12 to 14 |
| osc_en | output | 1 | Oscillator enable, low while cleared |
| strobe | output | 1 | One-cycle decode pulse, registered on the rising edge |
| tc | output | 1 | High while the count is all ones |

## Verification
The properties assume that `cmp` only changes while the count is steady. They also assume that `clr`, once raised, stays high across at least one clock edge, so that the clocked checks, which are turned off by `clr`, never have a clear fall between two samples. The bench drives `cmp` a little after a falling edge, raises `clr` a few nanoseconds after a falling edge, and holds it for several cycles before it drops it just after a rising edge. It takes the count through every tap boundary, stage 11 included, and through the wrap.

// File: rtl/divchain_pkg.sv
// Shared helpers for the tapped divider chain.
// Assumes: the chain has at least 12 stages, so that stage 11 exists and is hidden.
package divchain_pkg;

    // Stage number (1-based) that is kept inside and never brought out past stage 3
    localparam int HIDDEN_STAGE = 11;
    // Lowest stage that reaches a port
    localparam int FIRST_TAP    = 4;

    // Count bit that feeds tap i: stages from FIRST_TAP upward, skipping HIDDEN_STAGE
    function automatic int tap_bit(input int i);
        int s;
        s = i + FIRST_TAP;
        if (s >= HIDDEN_STAGE) s = s + 1;
        return s - 1;
    endfunction

endpackage

// File: rtl/divchain_release.sv
// Release of the asynchronous clear in step with the falling clock edge.
// Sets run on the first falling edge after clr drops. The counter only advances
// once run is high, so the first advance lands on the second falling edge.
// Assumes: clr may rise at any time; its fall is taken in by one flop.
module divchain_release (
    input  logic clk,
    input  logic clr,
    output logic run
);

    // Arming flop: cleared at once by clr, set by the next falling edge
    always_ff @(negedge clk or posedge clr) begin
        if (clr) run <= 1'b0;
        else     run <= 1'b1;
    end

endmodule

// File: rtl/divchain_count.sv
// Count register of the divider chain, clocked on the falling edge.
// All bits change together, so the taps carry no ripple skew.
// Assumes: run comes from divchain_release, in the same falling-edge domain.
module divchain_count #(
    parameter int STAGES = 14
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              run,
    output logic [STAGES-1:0] cnt,
    output logic              tc
);

    localparam logic [STAGES-1:0] ONE = STAGES'(1);

    // Advance by one per falling edge once armed; wraps naturally at all ones
    always_ff @(negedge clk or posedge clr) begin
        if (clr)      cnt <= '0;
        else if (run) cnt <= cnt + ONE;
    end

    // Terminal flag: every stage high
    always_comb tc = &cnt;

endmodule

// File: rtl/divchain_tapsel.sv
// Selects which stages of the count leave the block as divided clocks.
// Tap i takes stage i+4, skipping the hidden stage 11 (see divchain_pkg).
// Assumes: NTAPS equals STAGES-4.
module divchain_tapsel #(
    parameter int STAGES = 14,
    parameter int NTAPS  = STAGES - 4
) (
    input  logic [STAGES-1:0] cnt,
    output logic [NTAPS-1:0]  taps
);

    // One wire per tap, each picked from its count bit
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        localparam int B = divchain_pkg::tap_bit(i);
        assign taps[i] = cnt[B];
    end

endmodule

// File: rtl/divchain_match.sv
// Registered decode of the full count against a compare word.
// Sampled on the rising edge, half a period after the count settles on the
// falling edge, so the strobe carries no decode spikes.
// Assumes: cmp is steady around each rising edge.
module divchain_match #(
    parameter int STAGES = 14
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [STAGES-1:0] cnt,
    input  logic [STAGES-1:0] cmp,
    output logic              strobe
);

    // Equality decode taken on the rising edge; cleared at once by clr
    always_ff @(posedge clk or posedge clr) begin
        if (clr) strobe <= 1'b0;
        else     strobe <= (cnt == cmp);
    end

endmodule

// File: rtl/divchain_top.sv
// Tapped binary divider chain: arming flop, count register, tap selection,
// and registered decode strobe. osc_en follows clr so an oscillator model
// outside the block can stop while cleared.
// Assumes: clk is the oscillator clock; clr is asynchronous and active high.
module divchain_top #(
    parameter int  STAGES = 14,
    localparam int NTAPS  = STAGES - 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [STAGES-1:0] cmp,
    output logic [NTAPS-1:0]  taps,
    output logic              osc_en,
    output logic              strobe,
    output logic              tc
);

    logic              run_q;
    logic [STAGES-1:0] cnt_q;

    divchain_release u_rel (
        .clk (clk),
        .clr (clr),
        .run (run_q)
    );

    divchain_count #(.STAGES(STAGES)) u_cnt (
        .clk (clk),
        .clr (clr),
        .run (run_q),
        .cnt (cnt_q),
        .tc  (tc)
    );

    divchain_tapsel #(.STAGES(STAGES), .NTAPS(NTAPS)) u_tap (
        .cnt  (cnt_q),
        .taps (taps)
    );

    divchain_match #(.STAGES(STAGES)) u_match (
        .clk    (clk),
        .clr    (clr),
        .cnt    (cnt_q),
        .cmp    (cmp),
        .strobe (strobe)
    );

    // Oscillator stopped for as long as the clear is held
    always_comb osc_en = ~clr;

endmodule

// File: rtl/divchain_chk.sv
// Properties of the divider chain, bound to divchain_top.
// Assumes: cmp only changes while the count is steady; clr, once raised,
// stays high across at least one clock edge.
module divchain_chk #(
    parameter int STAGES = 14,
    parameter int NTAPS  = STAGES - 4
) (
    input logic              clk,
    input logic              clr,
    input logic              run,
    input logic [STAGES-1:0] cnt,
    input logic [STAGES-1:0] cmp,
    input logic [NTAPS-1:0]  taps,
    input logic              osc_en,
    input logic              strobe,
    input logic              tc
);

    // R1 R2
    count_step_chk: assert property (@(negedge clk) disable iff (clr)
        $past(run) |-> cnt == $past(cnt) + STAGES'(1));

    // R6
    first_edge_hold_chk: assert property (@(negedge clk) disable iff (clr)
        $rose(run) |-> cnt == '0);

    // R5
    osc_running_chk: assert property (@(negedge clk) disable iff (clr)
        run |-> osc_en);

    // R7
    strobe_match_chk: assert property (@(posedge clk) disable iff (clr)
        strobe |-> $past(cnt == cmp));

    // R8
    tc_wrap_chk: assert property (@(negedge clk) disable iff (clr)
        (tc && run) |=> taps == '0);

    // R4 R9
    always @(posedge clk) begin
        if (clr) begin
            clear_outputs_chk: assert (taps == '0 && !tc && !strobe);
        end
    end

endmodule

bind divchain_top divchain_chk #(.STAGES(STAGES), .NTAPS(NTAPS)) u_chk (
    .clk    (clk),
    .clr    (clr),
    .run    (run_q),
    .cnt    (cnt_q),
    .cmp    (cmp),
    .taps   (taps),
    .osc_en (osc_en),
    .strobe (strobe),
    .tc     (tc)
);

// File: tb/divchain_top_test.sv
module divchain_top_test;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [13:0] cmp = '0;
    logic [9:0]  taps;
    logic        osc_en, strobe, tc;

    int n_chk  = 0;
    int n_fail = 0;

    logic [13:0] exp_cnt = '0;
    logic        run_m   = 1'b0;

    // Target counts and the taps expected there (R3 mapping)
    localparam int NV = 10;
    localparam logic [13:0] TGT [NV] = '{14'd7, 14'd8, 14'd15, 14'd16, 14'd1023,
                                         14'd1024, 14'd2048, 14'd4104, 14'd8192, 14'd16383};
    localparam logic [9:0]  EXP [NV] = '{10'h000, 10'h001, 10'h001, 10'h002, 10'h07F,
                                         10'h000, 10'h080, 10'h101, 10'h200, 10'h3FF};

    always #10 clk = ~clk;

    divchain_top uut (
        .clk(clk), .clr(clr), .cmp(cmp),
        .taps(taps), .osc_en(osc_en), .strobe(strobe), .tc(tc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One falling edge, tracked in the bench model (R6 arming, R1 wrap)
    task automatic step();
        @(negedge clk);
        if (run_m) exp_cnt = exp_cnt + 14'd1;
        else       run_m = 1'b1;
    endtask

    task automatic advance_to(input logic [13:0] t);
        while (exp_cnt != t) step();
        #5;
    endtask

    task automatic release_clr();
        @(posedge clk);
        #2 clr = 1'b0;
        run_m = 1'b0;
        exp_cnt = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // Reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #5;
        check("R4 taps in clear", 32'(taps), 0);
        check("R5 osc_en in clear", 32'(osc_en), 0);
        check("R9 strobe in clear", 32'(strobe), 0);
        check("R9 tc in clear", 32'(tc), 0);

        // Release and recovery
        cmp = 14'd1;
        release_clr();
        #1 check("R5 osc_en after release", 32'(osc_en), 1);
        step();
        @(posedge clk); #5;
        check("R6 no advance on first edge", 32'(strobe), 0);
        step();
        @(posedge clk); #5;
        check("R6 R7 count 1 on second edge", 32'(strobe), 1);
        step();
        @(posedge clk); #5;
        check("R7 strobe lasts one cycle", 32'(strobe), 0);

        // Table walk over the tap boundaries
        cmp = 14'h3FFF;
        for (int e = 0; e < NV; e++) begin
            advance_to(TGT[e]);
            check("R3 taps", 32'(taps), 32'(EXP[e]));
            if (TGT[e] == 14'd7) begin
                @(posedge clk); #5;
                check("R2 rising edge holds taps", 32'(taps), 0);
            end
            if (TGT[e] == 14'd8192) check("R8 tc low", 32'(tc), 0);
        end
        check("R8 tc at all ones", 32'(tc), 1);
        @(posedge clk); #5;
        check("R7 strobe at compare", 32'(strobe), 1);

        // Wrap
        step(); #5;
        check("R1 wrap taps", 32'(taps), 0);
        check("R1 R8 wrap tc", 32'(tc), 0);
        advance_to(14'd8);
        check("R1 counting after wrap", 32'(taps), 10'h001);

        // Asynchronous clear in mid-run
        cmp = 14'd0;
        #3 clr = 1'b1;
        #1;
        check("R4 immediate clear", 32'(taps), 0);
        check("R5 osc_en drops", 32'(osc_en), 0);
        repeat (2) @(posedge clk);
        #5 check("R9 strobe held low", 32'(strobe), 0);

        // Counting resumes after a second release
        release_clr();
        advance_to(14'd8);
        check("R6 R3 resume after clear", 32'(taps), 10'h001);

        finish_run();
    end

endmodule